// File: doc/BRIEF.md
# Burst Memory Address Sequencer

This block supplies the word address for each cycle of a synchronous burst memory port. A cycle begins when one of two start strobes is seen with the chip selected. One strobe is on the processor side and the other is on the controller side. On that edge the full external address is captured. After that, the block walks the two least significant address bits through a four-word burst on each cycle where the advance input is active. It can walk them in linear order or in XOR-interleaved order. The upper address bits stay fixed for the whole burst.

Bursting is optional. A fresh external address may be started on every clock with no lost cycle. A valid flag marks the cycles whose address comes from a start or from an advance. The chip-select qualification of the strobes is part of the block, so a strobe seen while the chip is not selected can end a burst.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls with no strobe or advance, `addr_o` is 0 and `valid_o` is 0. No burst is open after reset.
- R2: The chip counts as selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A start happens when the chip is selected and `pstart_n`=0 or `cstart_n`=0. On the next clock `addr_o` equals the sampled `addr_i` and `valid_o`=1.
- R3: `pstart_n` is ignored while `ce1_n`=1, so it neither starts nor ends a burst. If an honoured strobe arrives while the chip is not selected, the open burst ends. In that case `valid_o` goes to 0 on the next clock and `addr_o` holds.
- R4: If both strobes are low on the same edge, exactly one load of `addr_i` takes place, and the processor-side strobe is the one that counts.
- R5: On an edge with an open burst, `adv_n`=0 and no strobe honoured, the burst count k (0..3) steps by one. The next `addr_o` low bits are then b XOR k when order is interleaved, or (b+k) mod 4 when order is linear. Here b is the loaded low pair. `valid_o` is 1 on that cycle.
- R6: `order_i`=1 selects linear order and `order_i`=0 selects interleaved order, which is the resting default. The value is captured at the start and holds for the whole burst.
- R7: The count wraps after four steps, so the fifth advance returns to b. The bits above bit 1 of `addr_o` never change on an advance.
- R8: On an edge with no strobe honoured and `adv_n`=1, `addr_o` holds its value and `valid_o` is 0.
- R9: Advance with no open burst, whether after reset or after a burst has ended, changes nothing and gives `valid_o`=0.
- R10: A start on the same edge as an advance is taken as a start. A start on every clock loads each new address with `valid_o`=1 on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | External word address |
| pstart_n | input | 1 | Processor-side start strobe, active low |
| cstart_n | input | 1 | Controller-side start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| order_i | input | 1 | 1 for linear order, 0 for interleaved order |
| addr_o | output | ADDR_W | Registered current word address |
| valid_o | output | 1 | Registered valid-cycle flag |

## Verification
The hardest case to reach from the ports is a linear burst from a non-zero base that passes the wrap point while strobes are also arriving during the burst. Some of those strobes are processor strobes hidden by `ce1_n`, which must leave the burst running. Others are controller strobes with the chip not selected, which must end it. Directed sequences walk every base value through more than four advances in both orders, with each kind of ignored or ending strobe placed in the middle. A long random phase then mixes every input, with strobes biased rare so that long bursts still occur. Every cycle is compared against a behavioural model in the bench.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int CNT_W = 2;

  typedef enum logic {
    ORD_INTLV  = 1'b0,
    ORD_LINEAR = 1'b1
  } burst_order_e;

  // Low address pair for burst step k from loaded pair b
  function automatic logic [CNT_W-1:0] burst_low(
    input logic [CNT_W-1:0] b,
    input logic [CNT_W-1:0] k,
    input burst_order_e     ord
  );
    logic [CNT_W-1:0] r;
    if (ord == ORD_LINEAR) r = b + k;
    else                   r = b ^ k;
    return r;
  endfunction

endpackage

// File: rtl/bsq_start_qual.sv
module bsq_start_qual (
  input  logic pstart_n,
  input  logic cstart_n,
  input  logic ce1_n,
  input  logic ce2,
  input  logic ce3_n,
  output logic start_o,
  output logic drop_o
);
  logic sel;
  logic p_honoured;
  logic any_stb;

  always_comb begin
    sel        = !ce1_n && ce2 && !ce3_n;
    // processor strobe only counts while first enable is active
    p_honoured = !pstart_n && !ce1_n;
    // processor strobe has priority; both lead to the same load
    any_stb    = p_honoured || !cstart_n;
    start_o    = any_stb && sel;
    drop_o     = any_stb && !sel;
  end
endmodule

// File: rtl/bsq_burst_ctr.sv
module bsq_burst_ctr #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          drop_i,
  input  logic          adv_i,
  output logic          step_o,
  output logic          live_o,
  output logic [CW-1:0] cnt_nxt_o
);
  logic [CW-1:0] cnt_q;
  logic          live_q;

  always_comb begin
    step_o    = live_q && adv_i && !load_i && !drop_i;
    cnt_nxt_o = cnt_q + 1'b1;
    live_o    = live_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      live_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= '0;
      live_q <= 1'b1;
    end else if (drop_i) begin
      live_q <= 1'b0;
    end else if (step_o) begin
      cnt_q  <= cnt_nxt_o;
    end
  end
endmodule

// File: rtl/bsq_order_map.sv
module bsq_order_map
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  burst_order_e      ord_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int UP_W = ADDR_W - CNT_W;

  generate
    if (UP_W > 0) begin : g_upper
      assign addr_o[ADDR_W-1:CNT_W] = base_i[ADDR_W-1:CNT_W];
    end
  endgenerate

  assign addr_o[CNT_W-1:0] = burst_low(base_i[CNT_W-1:0], cnt_i, ord_i);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              pstart_n,
  input  logic              cstart_n,
  input  logic              adv_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              order_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o
);
  logic              start, drop, step, live;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [ADDR_W-1:0] base_q, mapped;
  burst_order_e      ord_q;

  bsq_start_qual u_qual (
    .pstart_n (pstart_n),
    .cstart_n (cstart_n),
    .ce1_n    (ce1_n),
    .ce2      (ce2),
    .ce3_n    (ce3_n),
    .start_o  (start),
    .drop_o   (drop)
  );

  bsq_burst_ctr #(.CW(CNT_W)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .load_i    (start),
    .drop_i    (drop),
    .adv_i     (!adv_n),
    .step_o    (step),
    .live_o    (live),
    .cnt_nxt_o (cnt_nxt)
  );

  bsq_order_map #(.ADDR_W(ADDR_W)) u_map (
    .base_i (base_q),
    .cnt_i  (cnt_nxt),
    .ord_i  (ord_q),
    .addr_o (mapped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      ord_q   <= ORD_INTLV;
      addr_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= start || step;
      if (start) begin
        base_q <= addr_i;
        ord_q  <= burst_order_e'(order_i);
        addr_o <= addr_i;
      end else if (step) begin
        addr_o <= mapped;
      end
    end
  end

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (rst)
    (!ce1_n && ce2 && !ce3_n && (!pstart_n || !cstart_n)) |=> (valid_o && addr_o == $past(addr_i))) else $error("load"); // R2
  AST_PROC_MASKED: assert property (@(posedge clk) disable iff (rst)
    (ce1_n && cstart_n && adv_n) |=> ($stable(addr_o) && !valid_o)) else $error("masked"); // R3
  AST_DROP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cstart_n && !(!ce1_n && ce2 && !ce3_n)) |=> (!valid_o && $stable(addr_o))) else $error("drop"); // R3
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    (pstart_n && cstart_n && !adv_n) |=> (addr_o[ADDR_W-1:CNT_W] == $past(addr_o[ADDR_W-1:CNT_W]))) else $error("upper"); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pstart_n && cstart_n && adv_n) |=> ($stable(addr_o) && !valid_o)) else $error("hold"); // R8
  AST_ADV_NO_BURST: assert property (@(posedge clk) disable iff (rst)
    (pstart_n && cstart_n && !live) |=> (!valid_o && $stable(addr_o))) else $error("noburst"); // R9
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb_top;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] addr_i = '0;
  logic pstart_n = 1'b1, cstart_n = 1'b1, adv_n = 1'b1;
  logic ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0, order_i = 1'b0;
  logic [ADDR_W-1:0] addr_o;
  logic valid_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // behavioural model
  int m_base = 0, m_cnt = 0, m_addr = 0;
  bit m_lin = 0, m_live = 0, m_valid = 0;

  always #(CLK_P/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .addr_i(addr_i), .pstart_n(pstart_n),
    .cstart_n(cstart_n), .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .order_i(order_i), .addr_o(addr_o), .valid_o(valid_o)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // apply inputs, clock once, update model, compare
  task automatic cyc(int a, bit p, bit c, bit v, bit e1, bit e2, bit e3, bit o);
    string tag;
    bit pe, any, sel;
    int low;
    addr_i = a[ADDR_W-1:0]; pstart_n = p; cstart_n = c; adv_n = v;
    ce1_n = e1; ce2 = e2; ce3_n = e3; order_i = o;
    @(posedge clk);
    #1;
    pe  = !p && !e1;
    any = pe || !c;
    sel = !e1 && e2 && !e3;
    if (any && sel) begin
      tag = (!p && !c) ? "R4" : (!v ? "R10" : "R2");
      m_base = a; m_cnt = 0; m_lin = o; m_live = 1; m_valid = 1; m_addr = a;
    end else if (any) begin
      tag = "R3"; m_live = 0; m_valid = 0;
    end else if (!p && e1) begin
      tag = "R3"; m_valid = 0;
      if (!v && m_live) begin
        m_cnt = (m_cnt + 1) % 4; m_valid = 1;
      end
    end else if (!v && m_live) begin
      tag = (m_cnt == 3) ? "R7" : (m_lin ? "R6" : "R5");
      m_cnt = (m_cnt + 1) % 4; m_valid = 1;
    end else begin
      tag = v ? "R8" : "R9"; m_valid = 0;
    end
    if (m_valid && !(any && sel)) begin
      low = m_lin ? ((m_base + m_cnt) % 4) : ((m_base % 4) ^ m_cnt);
      m_addr = (m_base & ~3) | low;
    end
    check(tag, int'(addr_o), m_addr);
    check(tag, int'(valid_o), int'(m_valid));
  endtask

  // selected chip shorthands
  task automatic go_p(int a, bit o); cyc(a, 0, 1, 1, 0, 1, 0, o); endtask
  task automatic go_c(int a, bit o); cyc(a, 1, 0, 1, 0, 1, 0, o); endtask
  task automatic adv(); cyc(32'h5a5a5, 1, 1, 0, 0, 1, 0, 0); endtask
  task automatic idle(); cyc(32'h12345, 1, 1, 1, 0, 1, 0, 1); endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(addr_o), 0);
    check("R1", int'(valid_o), 0);
    @(negedge clk);
    rst = 1'b0;
    idle();                         // R1 quiet first cycle
    adv();                          // R9 advance with no open burst
    adv();
    // interleaved and linear bursts from every base, past the wrap (R5 R6 R7)
    for (int b = 0; b < 4; b++) begin
      go_p(32'h3a5c0 | b, 0);
      for (int k = 0; k < 6; k++) adv();
      go_c(32'h01230 | b, 1);
      for (int k = 0; k < 6; k++) adv();
    end
    // order pin change mid burst has no effect (R6)
    go_p(32'h77771, 1);
    cyc(0, 1, 1, 0, 0, 1, 0, 0);
    cyc(0, 1, 1, 0, 0, 1, 0, 0);
    // holding (R8)
    idle(); idle(); adv();
    // masked processor strobe keeps burst alive (R3)
    go_c(32'h4444e, 1);
    cyc(32'h99999, 0, 1, 0, 1, 1, 0, 0);
    cyc(32'h99999, 0, 1, 1, 1, 0, 1, 0);
    adv();
    // controller strobe with chip off ends burst (R3), then advance ignored (R9)
    cyc(32'h88888, 1, 0, 1, 0, 0, 0, 0);
    adv(); adv();
    go_p(32'h10002, 0); adv();
    cyc(32'h88888, 0, 1, 0, 0, 1, 1, 0);  // processor strobe, ce3 off: ends
    adv();
    // both strobes (R4), start with advance (R10), load every cycle (R10)
    cyc(32'hbeef3, 0, 0, 1, 0, 1, 0, 1);
    adv();
    cyc(32'hcafe1, 0, 1, 0, 0, 1, 0, 0);
    cyc(32'hcafe2, 1, 0, 0, 0, 1, 0, 1);
    for (int i = 0; i < 8; i++) go_p(i * 32'h1111 + i, i[0]);
    adv();
    // random mix, strobes rare
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 16;
      cyc($urandom % (1 << ADDR_W), r != 0, r != 1 && r != 2,
          ($urandom % 4) == 0, ($urandom % 5) == 0, ($urandom % 5) != 0,
          ($urandom % 5) == 0, $urandom % 2);
    end
    // reset again mid burst (R1)
    go_p(32'h0abc3, 1); adv();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R1", int'(addr_o), 0);
    check("R1", int'(valid_o), 0);
    @(negedge clk);
    rst = 1'b0;
    m_addr = 0; m_live = 0; m_valid = 0; m_cnt = 0; m_base = 0; m_lin = 0;
    adv();                          // R9 no burst after reset
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule